// File: doc/BRIEF.md
# Store Queue with Read Bypass

This block sits between a write-through cache and main memory. Each processor store goes into the cache and, in the same cycle, into a four-entry queue that holds an address, a data word and byte enables. The queue sends its stores to memory through one shared port, strictly oldest first and one per accepted handshake. If stores arrive faster than memory accepts them, the queue fills and the store port stalls. No store is ever dropped.

A read miss does not wait behind the queued stores. Its word address is first compared with every occupied slot. If the youngest matching slot covers the whole word, its data goes straight back to the requester and memory is not touched. If the youngest match covers only some bytes, the queue keeps draining until no slot matches, and the read is issued afterwards. If nothing matches, the read takes the memory port ahead of every queued store.

A small state machine controls the read path. Its states are IDLE, LOOKUP, DRAIN and ISSUE. The transitions are:
- IDLE to LOOKUP when a request arrives.
- LOOKUP to IDLE when the youngest match covers the full word (forward).
- LOOKUP to DRAIN when the youngest match is partial.
- LOOKUP to ISSUE when there is no match.
- DRAIN to ISSUE once no slot matches.
- ISSUE to IDLE when memory accepts the read.

Top module: `wbuf_bypass`

## Requirements
- R1: After reset the queue is empty: `mem_valid`, `st_stall` and `rd_done` are all low.
- R2: An accepted store leaves through the memory port with its address, data and byte enables unchanged, and stores leave in the order they were accepted (`mem_we`=1 marks a write).
- R3: With four stores held and no write accepted by memory in the current cycle, `st_stall` is high and the store on the port is neither taken nor lost.
- R4: When the queue is full and memory accepts a write in the same cycle, `st_stall` is low and the new store is taken in that cycle, so the occupancy stays at four.
- R5: A read whose word matches no held store is sent to memory (`mem_we`=0) without waiting for the queue to drain. `rd_done` rises three cycles after the request is sampled when memory is ready, with `rd_fwd`=0.
- R6: A read whose youngest matching store has all byte enables set returns that store's data with `rd_fwd`=1, issues no memory read, and raises `rd_done` two cycles after the request is sampled.
- R7: A read whose youngest matching store has some byte enable clear waits until no held store matches. It then reads memory, so the returned word includes every matching store.
- R8: While a read is being issued, no write is presented on the memory port, and the read is accepted before older, non-matching queued stores.
- R9: `rd_done` is a one-cycle pulse, and a new request is sampled only in a cycle where `rd_done` is low.
- R10: Addresses are compared on whole words. The byte-offset bits (bits 1:0 for 32-bit data) play no part in a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered |
| st_addr | input | AW | Store byte address |
| st_data | input | DW | Store data |
| st_be | input | DW/8 | Store byte enables |
| st_stall | output | 1 | Store not accepted this cycle |
| rd_req | input | 1 | Read miss request, held until `rd_done` |
| rd_addr | input | AW | Read byte address |
| rd_done | output | 1 | Read result valid (one cycle) |
| rd_data | output | DW | Read result |
| rd_fwd | output | 1 | Result came from the queue |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Write data |
| mem_be | output | DW/8 | Write byte enables (all ones on reads) |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | DW | Read data, valid when a read is accepted |

## Verification
The bench counts clock edges from the one that samples a request:
- A forwarded read is due at the second edge.
- A clean read with ready memory is due at the third edge.
- A partial-match read is due two edges after the last matching store drains.

The bench waits on `rd_done` at falling edges and checks that edge count. Stall behaviour is combinational, so it is checked just after inputs are driven, before the next rising edge. Drain order and read priority are checked against a log kept by the bench memory, including the number of writes it had taken when the read arrived.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
    typedef enum logic [1:0] {
        RD_IDLE,
        RD_LOOKUP,
        RD_DRAIN,
        RD_ISSUE
    } rd_state_e;
endpackage

// File: rtl/wbuf_fifo.sv
module wbuf_fifo #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int BEW   = DW / 8,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic [AW-1:0]                 push_addr,
    input  logic [DW-1:0]                 push_data,
    input  logic [BEW-1:0]                push_be,
    input  logic                          pop,
    output logic                          full,
    output logic                          empty,
    output logic [PW-1:0]                 head_ptr,
    output logic [DEPTH-1:0]              slot_valid,
    output logic [DEPTH-1:0][AW-1:0]      slot_addr,
    output logic [DEPTH-1:0][DW-1:0]      slot_data,
    output logic [DEPTH-1:0][BEW-1:0]     slot_be
);
    logic [PW-1:0]    wr_ptr;
    logic [PW-1:0]    rd_ptr;
    logic [DEPTH-1:0] vld;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            vld    <= '0;
        end else begin
            if (pop) begin
                vld[rd_ptr] <= 1'b0;
                rd_ptr      <= rd_ptr + 1'b1;
            end
            if (push) begin
                vld[wr_ptr] <= 1'b1;
                wr_ptr      <= wr_ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            slot_addr[wr_ptr] <= push_addr;
            slot_data[wr_ptr] <= push_data;
            slot_be[wr_ptr]   <= push_be;
        end
    end

    assign full       = &vld;
    assign empty      = ~|vld;
    assign head_ptr   = rd_ptr;
    assign slot_valid = vld;

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |-> pop);

    // R2
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/wbuf_match.sv
module wbuf_match #(
    parameter int DEPTH = 4,
    parameter int WAW   = 30,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic [WAW-1:0]              q_wa,
    input  logic [DEPTH-1:0][WAW-1:0]   slot_wa,
    input  logic [DEPTH-1:0]            slot_full,
    input  logic [DEPTH-1:0]            slot_valid,
    input  logic [PW-1:0]               head_ptr,
    output logic                        any_hit,
    output logic                        young_full,
    output logic [PW-1:0]               young_slot
);
    logic [DEPTH-1:0] hit;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit[g] = slot_valid[g] && (slot_wa[g] == q_wa);
    end

    always_comb begin
        any_hit    = 1'b0;
        young_full = 1'b0;
        young_slot = '0;
        for (int k = 0; k < DEPTH; k++) begin
            logic [PW-1:0] s;
            s = head_ptr + PW'(k);
            if (hit[s]) begin
                any_hit    = 1'b1;
                young_full = slot_full[s];
                young_slot = s;
            end
        end
    end
endmodule

// File: rtl/wbuf_bypass.sv
module wbuf_bypass
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    input  logic [AW-1:0]     st_addr,
    input  logic [DW-1:0]     st_data,
    input  logic [DW/8-1:0]   st_be,
    output logic              st_stall,
    input  logic              rd_req,
    input  logic [AW-1:0]     rd_addr,
    output logic              rd_done,
    output logic [DW-1:0]     rd_data,
    output logic              rd_fwd,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    output logic [DW/8-1:0]   mem_be,
    input  logic              mem_ready,
    input  logic [DW-1:0]     mem_rdata
);
    localparam int BEW = DW / 8;
    localparam int OFF = $clog2(BEW);
    localparam int WAW = AW - OFF;
    localparam int PW  = $clog2(DEPTH);

    rd_state_e state, nxt;
    logic [AW-1:0] rd_addr_q;

    logic                      full, empty, push, pop;
    logic [PW-1:0]             head_ptr;
    logic [DEPTH-1:0]          slot_valid;
    logic [DEPTH-1:0][AW-1:0]  slot_addr;
    logic [DEPTH-1:0][DW-1:0]  slot_data;
    logic [DEPTH-1:0][BEW-1:0] slot_be;
    logic [DEPTH-1:0][WAW-1:0] slot_wa;
    logic [DEPTH-1:0]          slot_full;
    logic                      any_hit, young_full;
    logic [PW-1:0]             young_slot;
    logic                      rd_issue;

    wbuf_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .BEW(BEW)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_addr(st_addr), .push_data(st_data), .push_be(st_be),
        .pop(pop), .full(full), .empty(empty), .head_ptr(head_ptr),
        .slot_valid(slot_valid), .slot_addr(slot_addr),
        .slot_data(slot_data), .slot_be(slot_be)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign slot_wa[g]   = slot_addr[g][AW-1:OFF];
        assign slot_full[g] = &slot_be[g];
    end

    wbuf_match #(.DEPTH(DEPTH), .WAW(WAW)) u_match (
        .q_wa(rd_addr_q[AW-1:OFF]), .slot_wa(slot_wa), .slot_full(slot_full),
        .slot_valid(slot_valid), .head_ptr(head_ptr),
        .any_hit(any_hit), .young_full(young_full), .young_slot(young_slot)
    );

    // memory port arbitration: an issuing read wins, else the oldest store
    assign rd_issue  = (state == RD_ISSUE);
    assign mem_valid = rd_issue || !empty;
    assign mem_we    = !rd_issue;
    assign mem_addr  = rd_issue ? rd_addr_q : slot_addr[head_ptr];
    assign mem_wdata = slot_data[head_ptr];
    assign mem_be    = rd_issue ? {BEW{1'b1}} : slot_be[head_ptr];
    assign pop       = !rd_issue && !empty && mem_ready;
    assign st_stall  = full && !pop;
    assign push      = st_valid && !st_stall;

    always_comb begin
        nxt = state;
        unique case (state)
            RD_IDLE:   if (rd_req && !rd_done) nxt = RD_LOOKUP;
            RD_LOOKUP: begin
                if (any_hit && young_full) nxt = RD_IDLE;
                else if (any_hit)          nxt = RD_DRAIN;
                else                       nxt = RD_ISSUE;
            end
            RD_DRAIN:  if (!any_hit)  nxt = RD_ISSUE;
            RD_ISSUE:  if (mem_ready) nxt = RD_IDLE;
            default:   nxt = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RD_IDLE;
            rd_addr_q <= '0;
        end else begin
            state <= nxt;
            if (state == RD_IDLE && nxt == RD_LOOKUP) rd_addr_q <= rd_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_done <= 1'b0;
            rd_fwd  <= 1'b0;
            rd_data <= '0;
        end else begin
            rd_done <= 1'b0;
            if (state == RD_LOOKUP && any_hit && young_full) begin
                rd_done <= 1'b1;
                rd_fwd  <= 1'b1;
                rd_data <= slot_data[young_slot];
            end else if (rd_issue && mem_ready) begin
                rd_done <= 1'b1;
                rd_fwd  <= 1'b0;
                rd_data <= mem_rdata;
            end
        end
    end

    // R5
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_we) |-> !any_hit);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);

    // R6
    fwd_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && rd_fwd) |-> !$past(mem_valid && !mem_we && mem_ready));
endmodule

// File: tb/tb_wbuf_bypass.sv
module tb_wbuf_bypass;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        st_valid = 0;
    logic [31:0] st_addr = 0, st_data = 0;
    logic [3:0]  st_be = 0;
    logic        st_stall;
    logic        rd_req = 0;
    logic [31:0] rd_addr = 0;
    logic        rd_done, rd_fwd;
    logic [31:0] rd_data;
    logic        mem_valid, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_be;
    logic        wr_rdy = 0;

    int n_chk = 0, n_fail = 0;

    logic [31:0] mem [16];
    logic [31:0] wlog_a [16];
    logic [31:0] wlog_d [16];
    int wcnt = 0, rcnt = 0, wcnt_at_rd = 0;

    always #5 clk = ~clk;

    wbuf_bypass dut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
        .st_stall(st_stall),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_done(rd_done), .rd_data(rd_data),
        .rd_fwd(rd_fwd),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata)
    );

    assign mem_ready = mem_we ? wr_rdy : 1'b1;
    assign mem_rdata = mem[mem_addr[5:2]];

    initial for (int i = 0; i < 16; i++) mem[i] = 32'hA000_0000 + i;

    always @(posedge clk) begin
        if (mem_valid && mem_ready) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[5:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
                wlog_a[wcnt % 16] <= mem_addr;
                wlog_d[wcnt % 16] <= mem_wdata;
                wcnt <= wcnt + 1;
            end else begin
                rcnt       <= rcnt + 1;
                wcnt_at_rd <= wcnt;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; st_valid = 0; rd_req = 0; wr_rdy = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic do_push(input logic [31:0] a, input logic [31:0] d, input logic [3:0] b);
        @(negedge clk);
        st_valid = 1; st_addr = a; st_data = d; st_be = b;
        @(posedge clk);
        #1 st_valid = 0;
    endtask

    task automatic do_read(input logic [31:0] a, input bit rel,
                           output logic [31:0] d, output logic f, output int lat);
        @(negedge clk);
        rd_req = 1; rd_addr = a; lat = 0;
        if (rel) wr_rdy = 1;
        do begin
            @(negedge clk);
            lat++;
        end while (!rd_done && lat < 50);
        d = rd_data; f = rd_fwd;
        rd_req = 0;
    endtask

    typedef struct packed {
        logic [31:0] a0; logic [31:0] d0; logic [3:0] b0;
        logic [31:0] a1; logic [31:0] d1; logic [3:0] b1;
        logic [31:0] ra; logic [31:0] exp; logic fwd;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{32'h10, 32'hD1D1_D1D1, 4'hF, 32'h14, 32'hD2D2_D2D2, 4'hF, 32'h10, 32'hD1D1_D1D1, 1'b1},
        '{32'h10, 32'hD1D1_D1D1, 4'hF, 32'h10, 32'hD3D3_D3D3, 4'hF, 32'h10, 32'hD3D3_D3D3, 1'b1},
        '{32'h10, 32'hD1D1_D1D1, 4'hF, 32'h20, 32'hD4D4_D4D4, 4'hF, 32'h30, 32'hA000_000C, 1'b0},
        '{32'h10, 32'h0000_5555, 4'h3, 32'h10, 32'hD6D6_D6D6, 4'hF, 32'h13, 32'hD6D6_D6D6, 1'b1}
    };

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic f;
        int lat, wb, rb;

        do_reset();
        // R1 reset state
        chk(mem_valid == 0, "R1 mem_valid", 32'(mem_valid), 0);
        chk(st_stall == 0, "R1 st_stall", 32'(st_stall), 0);
        chk(rd_done == 0, "R1 rd_done", 32'(rd_done), 0);

        // table: R5 R6 R10 with stores held back from memory
        for (int v = 0; v < 4; v++) begin
            do_reset();
            wb = wcnt; rb = rcnt;
            do_push(VEC[v].a0, VEC[v].d0, VEC[v].b0);
            do_push(VEC[v].a1, VEC[v].d1, VEC[v].b1);
            do_read(VEC[v].ra, 0, d, f, lat);
            chk(d == VEC[v].exp, "R6/R5/R10 data", d, VEC[v].exp);
            chk(f == VEC[v].fwd, "R6/R5 fwd", 32'(f), 32'(VEC[v].fwd));
            chk(lat == (VEC[v].fwd ? 2 : 3), "R6/R5 latency", 32'(lat), VEC[v].fwd ? 2 : 3);
            chk(rcnt - rb == (VEC[v].fwd ? 0 : 1), "R6 mem reads", 32'(rcnt - rb), VEC[v].fwd ? 0 : 1);
            chk(wcnt == wb, "R5 bypass ahead of writes", 32'(wcnt - wb), 0);
            @(negedge clk);
            chk(rd_done == 0, "R9 pulse", 32'(rd_done), 0);
        end

        // R3 R4 R2: fill, stall, push with pop when full, drain order
        do_reset();
        wb = wcnt;
        for (int i = 0; i < 4; i++) do_push(32'h40 + 4*i, 32'hE0 + i, 4'hF);
        @(negedge clk);
        st_valid = 1; st_addr = 32'h50; st_data = 32'hE4; st_be = 4'hF;
        #1 chk(st_stall == 1, "R3 stall when full", 32'(st_stall), 1);
        @(negedge clk);
        chk(st_stall == 1, "R3 stall held", 32'(st_stall), 1);
        wr_rdy = 1;
        #1 chk(st_stall == 0, "R4 push with pop when full", 32'(st_stall), 0);
        @(posedge clk);
        #1 st_valid = 0;
        repeat (8) @(negedge clk);
        chk(wcnt - wb == 5, "R2/R4 write count", 32'(wcnt - wb), 5);
        for (int i = 0; i < 5; i++) begin
            chk(wlog_a[(wb + i) % 16] == 32'h40 + 4*i, "R2 order addr", wlog_a[(wb + i) % 16], 32'h40 + 4*i);
            chk(wlog_d[(wb + i) % 16] == 32'hE0 + i, "R2 data", wlog_d[(wb + i) % 16], 32'hE0 + i);
        end

        // R7 partial youngest match drains first
        do_reset();
        wb = wcnt;
        do_push(32'h60, 32'h1111_1111, 4'hF);
        do_push(32'h64, 32'h2222_2222, 4'hF);
        do_push(32'h60, 32'h0000_0022, 4'h1);
        do_read(32'h60, 1, d, f, lat);
        chk(d == 32'h1111_1122, "R7 merged data", d, 32'h1111_1122);
        chk(f == 0, "R7 not forwarded", 32'(f), 0);
        chk(wcnt_at_rd - wb == 3, "R7 drained before read", 32'(wcnt_at_rd - wb), 3);

        // R8 read takes port ahead of older non-matching stores
        do_reset();
        wb = wcnt;
        for (int i = 0; i < 4; i++) do_push(32'h80 + 4*i, 32'hC0 + i, 4'hF);
        do_read(32'h78, 1, d, f, lat);
        chk(d == 32'hA000_000E, "R8 read data", d, 32'hA000_000E);
        chk(lat == 3, "R8 latency", 32'(lat), 3);
        chk(wcnt_at_rd - wb == 2, "R8 read overtook", 32'(wcnt_at_rd - wb), 2);
        chk(wcnt - wb == 2, "R8 no write with read", 32'(wcnt - wb), 2);
        repeat (6) @(negedge clk);
        chk(wcnt - wb == 4, "R8 remaining drained", 32'(wcnt - wb), 4);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule